// File: doc/BRIEF.md
# Half-Step Predivide Clock Divider

This block derives a slow rate from one of three reference tick streams: a crystal tick, a first PLL tick and a second PLL tick. All three are presented as single-cycle enables in the system clock domain. The selected stream first passes through a predivider that divides by 2, 2.5 or 3. The divide by 2.5 is made by alternating stages of two and three source ticks. An integer stage then divides the predivider output by 2 to 127. Each completed output period produces a one-cycle pulse on `div_pulse`, which downstream logic uses as a clock enable.

Software drives a 15-bit configuration word. That word holds the divisor, the predivide code and the two source-select bits. A separate enable input gates the block. The working copy of the configuration is taken only when a period ends, or while the block is idle. A rewrite therefore never shortens or stretches the period in flight. While the block is disabled, or while its working configuration is illegal, both counters are held cleared and no pulse is produced.

Top module: `frac_clk_div`

## Requirements
- R1: During and directly after reset, `div_pulse` is 0, and it stays 0 until the block is enabled with a legal configuration.
- R2: Configuration bit 14 clear selects the crystal tick. With bit 14 set, bit 13 clear selects the first PLL tick and bit 13 set selects the second. Ticks on the streams that are not selected have no effect on the output.
- R3: Predivide code 1 (bits 9:8) makes every output period exactly 2×D selected ticks long, where D is the divisor.
- R4: Predivide code 3 makes every output period exactly 3×D selected ticks long.
- R5: Predivide code 2 alternates predivide stages of 2 and 3 ticks. The first stage after enable, or after an illegal configuration, is 2 ticks, and the alternation carries across period boundaries. A period that starts on a short stage is 2D+floor(D/2) ticks, otherwise 2D+ceil(D/2).
- R6: The divisor sits in bits 6:0 and accepts 2 to 127. With D=2 and code 1 the output period is 4 ticks (the fastest), and with D=127 and code 3 it is 381 ticks.
- R7: A working configuration with code 0 or a divisor below 2 keeps `div_pulse` at 0. While it holds, the configuration input is reloaded every cycle.
- R8: While the block is running, a change on `cfg` takes effect only at the end of the current output period and never alters the period in flight.
- R9: While `en` is 0, `div_pulse` is 0 and both counters are cleared. After re-enabling, the first period is a full period counted from zero.
- R10: `div_pulse` is high for exactly one system clock cycle: the cycle after the edge that sampled the tick completing the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_xtal | input | 1 | Crystal reference tick, one cycle per source period |
| tick_pll1 | input | 1 | First PLL reference tick |
| tick_pll2 | input | 1 | Second PLL reference tick |
| cfg | input | 15 | Divisor [6:0], predivide code [9:8], PLL select [13], external select [14] |
| en | input | 1 | Divider enable |
| div_pulse | output | 1 | One-cycle pulse at the end of each output period |

## Verification
The bench builds the block with its default 7-bit divisor field, so every divisor from 2 to 127 can be reached. That covers both the fastest 4-tick period and the 381-tick period at the top of the range. Random tick densities and random configurations exercise all three predivide codes. Mid-period rewrites and short disables show that reloads happen only at period boundaries. Directed runs of the half-step mode with odd divisors show the 2/3 alternation carrying across period ends.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int DIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_xtal,
  input  logic        tick_pll1,
  input  logic        tick_pll2,
  input  logic [14:0] cfg,
  input  logic        en,
  output logic        div_pulse
);
  localparam int CODE_LO = 8;
  localparam int PSEL    = 13;
  localparam int ESEL    = 14;

  logic [14:0]      act;
  logic [1:0]       pre_cnt;
  logic             half;
  logic [DIV_W-1:0] div_cnt;
  logic             pulse_q;

  wire [DIV_W-1:0] a_div  = act[DIV_W-1:0];
  wire [1:0]       a_code = act[CODE_LO+1:CODE_LO];
  wire legal = (a_code != 2'd0) && (a_div >= DIV_W'(2));
  wire src   = !act[ESEL] ? tick_xtal : (act[PSEL] ? tick_pll2 : tick_pll1);

  wire [1:0] pre_len = (a_code == 2'd1) ? 2'd2 :
                       (a_code == 2'd3) ? 2'd3 : (half ? 2'd3 : 2'd2);
  wire pre_done   = src && (2'(pre_cnt + 2'd1) == pre_len);
  wire period_end = pre_done && (DIV_W'(div_cnt + 1'b1) == a_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= '0;
      pre_cnt <= '0;
      half    <= 1'b0;
      div_cnt <= '0;
      pulse_q <= 1'b0;
    end else if (!en || !legal) begin
      act     <= cfg;
      pre_cnt <= '0;
      half    <= 1'b0;
      div_cnt <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= period_end;
      if (src) begin
        if (pre_done) begin
          pre_cnt <= '0;
          if (a_code == 2'd2) half <= ~half;
          if (period_end) begin
            div_cnt <= '0;
            act     <= cfg;
          end else begin
            div_cnt <= DIV_W'(div_cnt + 1'b1);
          end
        end else begin
          pre_cnt <= 2'(pre_cnt + 2'd1);
        end
      end
    end
  end

  assign div_pulse = pulse_q;
endmodule

module frac_clk_div_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        pulse,
  input logic        legal,
  input logic        src,
  input logic        period_end,
  input logic [14:0] act
);
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R9
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pulse);
  // R7
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> !pulse);
  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(src));
  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && legal && !period_end) |=> $stable(act));
endmodule

bind frac_clk_div frac_clk_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pulse(div_pulse), .legal(legal),
  .src(src), .period_end(period_end), .act(act)
);

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, en = 0;
  logic [2:0] ticks = 0;
  logic [14:0] cfg = 0;
  logic div_pulse;
  int checks = 0, errors = 0, cnum = 0;
  bit done = 0;
  string tag = "R1";

  logic [14:0] m_act = 0;
  bit m_ph = 0, m_exp = 0;
  int m_rem = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_clk_div u_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .tick_xtal(ticks[0]), .tick_pll1(ticks[1]),
    .tick_pll2(ticks[2]), .cfg(cfg), .en(en), .div_pulse(div_pulse)
  );

  function automatic bit ok_cfg(input logic [14:0] c);
    return c[9:8] != 0 && c[6:0] >= 2;
  endfunction

  function automatic int per(input logic [14:0] c, input bit ph);
    int d = c[6:0];
    case (c[9:8])
      2'd1: return 2*d;
      2'd3: return 3*d;
      2'd2: return 2*d + (ph ? (d+1)/2 : d/2);
      default: return 0;
    endcase
  endfunction

  function automatic bit pick(input logic [14:0] c, input logic [2:0] t);
    return !c[14] ? t[0] : (c[13] ? t[2] : t[1]);
  endfunction

  function automatic logic [14:0] mk(input int esel, input int psel,
                                     input int code, input int d);
    return 15'((esel << 14) | (psel << 13) | (code << 8) | d);
  endfunction

  task automatic cyc(input logic [2:0] t);
    ticks = t;
    @(posedge clk);
    cnum++;
    if (!rst_n) begin
      m_act = 0; m_ph = 0; m_exp = 0; m_rem = 0;
    end else if (!en || !ok_cfg(m_act)) begin
      m_act = cfg; m_ph = 0; m_exp = 0; m_rem = per(cfg, 0);
    end else begin
      m_exp = 0;
      if (pick(m_act, t)) begin
        m_rem--;
        if (m_rem == 0) begin
          m_exp = 1;
          if (m_act[9:8] == 2) m_ph ^= m_act[0];
          m_act = cfg;
          m_rem = per(cfg, m_ph);
        end
      end
    end
    @(negedge clk);
    checks++;
    if (div_pulse !== m_exp) begin
      errors++;
      $display("FAIL %s: div_pulse=%0b expected=%0b at cycle %0d",
               tag, div_pulse, m_exp, cnum);
    end
  endtask

  task automatic run(input int n, input int dens);
    for (int i = 0; i < n; i++) begin
      logic [2:0] t;
      t[0] = ($urandom % 100) < dens;
      t[1] = ($urandom % 100) < dens;
      t[2] = ($urandom % 100) < dens;
      cyc(t);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: expired=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d5eed));
    @(negedge clk);
    tag = "R1";
    for (int i = 0; i < 5; i++) cyc(3'b111);
    rst_n = 1;
    run(20, 60);
    // R6 fastest rate: crystal, code 1, divisor 2, tick every cycle
    tag = "R6";
    cfg = mk(0, 0, 1, 2); en = 1;
    for (int i = 0; i < 40; i++) cyc(3'b001);
    // R2/R4 first PLL selected, others toggling
    tag = "R4";
    en = 0; cyc(0); cfg = mk(1, 0, 3, 5); cyc(0); en = 1;
    run(400, 50);
    tag = "R2";
    for (int i = 0; i < 200; i++) cyc(3'b101);
    // R5 half step on second PLL, odd divisors
    tag = "R5";
    en = 0; cfg = mk(1, 1, 2, 3); cyc(0); en = 1;
    run(600, 70);
    cfg = mk(1, 1, 2, 7); run(800, 70);
    // R3 code 1
    tag = "R3";
    cfg = mk(0, 1, 1, 9); run(600, 40);
    // R6 largest divisor
    tag = "R6";
    cfg = mk(0, 0, 3, 127); run(2000, 90);
    // R7 illegal codes
    tag = "R7";
    cfg = mk(0, 0, 0, 20); run(300, 80);
    cfg = mk(0, 0, 1, 1); run(300, 80);
    cfg = mk(0, 0, 1, 0); run(100, 80);
    // R8 rewrite mid period
    tag = "R8";
    cfg = mk(0, 0, 1, 10); run(5, 100);
    cfg = mk(0, 0, 1, 2); run(8, 100);
    cfg = mk(1, 1, 3, 4); run(300, 60);
    // R9 disable mid period and restart
    tag = "R9";
    cfg = mk(0, 0, 2, 5); run(12, 100);
    en = 0; run(30, 100);
    en = 1; run(200, 100);
    // R10 random segments
    tag = "R10";
    for (int s = 0; s < 40; s++) begin
      int code = 1 + $urandom % 3;
      int d = ($urandom % 4 == 0) ? 2 + $urandom % 126 : 2 + $urandom % 20;
      cfg = mk($urandom % 2, $urandom % 2, code, d);
      if ($urandom % 8 == 0) cfg[9:8] = 0;
      run(400, 20 + $urandom % 80);
      if ($urandom % 3 == 0) begin en = 0; run(5, 50); en = 1; end
      cfg = mk($urandom % 2, $urandom % 2, 1 + $urandom % 3, 2 + $urandom % 30);
      run(400, 20 + $urandom % 80);
    end
    finish_run();
  end
endmodule